// File: doc/BRIEF.md
# CTS Change Interrupt with Edge-Triggered Clear

This block raises an interrupt whenever the clear-to-send input of a serial port changes level. The input goes through a synchronizer clocked by the port clock. When two consecutive synchronized samples differ, a raw status flag is set. A mask bit gates the raw flag onto the interrupt line. Software reads the raw and masked flags through a small word-addressed register port and clears the flag by writing to a write-only clear register.

The clear path copies a particular piece of hardware behaviour, on purpose. A write to the clear register loads a hidden one-bit latch. The flag is cleared only when that latch goes from 0 to 1. Hardware drops the latch back to 0 by itself, but only once the flag reads 0.

A CTS change always takes priority over a clear. If both land in the same cycle, the flag stays set and the latch stays at 1, so repeated writes of 1 do nothing. Software can always recover by writing 0 and then writing 1 in a later cycle.

Top module: `cts_edge_irq`

## Requirements
- R1: While the active-low synchronous reset is asserted, the block clears the raw flag, the mask, the hidden clear latch and the synchronizer. After reset, `rawStatus`, `maskedStatus` and `irqOut` are 0, and every register reads 0.
- R2: Any change of level on `ctsIn` sets the raw flag. With two synchronizer stages, the flag reads 1 after the third rising clock edge that follows the change.
- R3: Writing a word with bit 1 set to the clear register (address 3) clears the raw flag at the next edge. This needs the hidden latch to be 0 and no CTS change detected in the same cycle. A clear write of 1 made while the flag is already 0 leaves the flag at 0.
- R4: If a detected CTS change and an effective clear fall in the same cycle, the flag stays 1 and the hidden latch ends at 1.
- R5: While the hidden latch holds 1, further writes of 1 to the clear register leave the flag unchanged. A write of 0 to the clear register loads 0 into the latch and also leaves the flag unchanged.
- R6: A write of 0 to the clear register followed by a write of 1 in the next cycle clears a locked flag. After a normal clear, the latch returns to 0 one cycle after the flag reads 0, so the next single write of 1 clears again.
- R7: The mask is bit 1 of address 2. `maskedStatus` equals the raw flag ANDed with the mask, and `irqOut` equals `maskedStatus`.
- R8: `regRdData` returns the raw flag in bit 1 at address 0, the masked flag in bit 1 at address 1 and the mask in bit 1 at address 2. Address 3 always reads 0, and all other bits always read 0.
- R9: Writes to addresses 0 and 1 have no effect.
- R10: With no CTS change and no effective clear, the raw flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial port clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctsIn | input | 1 | Asynchronous clear-to-send line |
| regAddr | input | ADDR_W | Word address (0 raw, 1 masked, 2 mask, 3 clear) |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | DATA_W | Write data, bit 1 used |
| regRdData | output | DATA_W | Read data for `regAddr`, combinational |
| rawStatus | output | 1 | Raw CTS change flag |
| maskedStatus | output | 1 | Raw flag gated by the mask |
| irqOut | output | 1 | Interrupt request |

## Verification
The hidden latch cannot be read, so the bench can only see a wrong latch value through `rawStatus`. A latch that is wrongly high makes the next clear write of 1 do nothing, and the flag then still reads 1 one edge later. A latch that is wrongly low turns a write of 1 after a collision into a clear. The collision case is aimed so that the CTS change reaches the detector in exactly the cycle of the clear write. The clear-after-collision and 0-then-1 recovery sequences then show any latch error within one edge of the write that depends on it.

// File: rtl/cts_irq_pkg.sv
package cts_irq_pkg;

  // Bit position of the single implemented field in every register word
  localparam int STAT_BIT = 1;

  typedef enum logic [1:0] {
    SEL_RAW   = 2'd0,
    SEL_MSKD  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_CLEAR = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic maskWe;
    logic maskVal;
    logic clrEvt;
  } ctlStrobe_t;

endpackage

// File: rtl/cts_sync_edge.sv
module cts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctsIn,
  output logic edgeSeen
);

  logic [STAGES-1:0] chain;
  logic              prevLvl;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= ctsIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= chain[STAGES-1];
  end

  assign edgeSeen = chain[STAGES-1] ^ prevLvl;

endmodule

// File: rtl/cts_irq_dp.sv
module cts_irq_dp
  import cts_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsIn,
  input  ctlStrobe_t strobe,
  output logic       edgeSeen,
  output logic       rawStatus,
  output logic       maskBit
);

  cts_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctsIn    (ctsIn),
    .edgeSeen (edgeSeen)
  );

  // A detected change outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawStatus <= 1'b0;
    end else if (edgeSeen) begin
      rawStatus <= 1'b1;
    end else if (strobe.clrEvt) begin
      rawStatus <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              maskBit <= 1'b0;
    else if (strobe.maskWe) maskBit <= strobe.maskVal;
  end

endmodule

// File: rtl/cts_irq_ctl.sv
module cts_irq_ctl
  import cts_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rawStatus,
  input  logic              maskBit,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] regRdData,
  output logic              clrWrite,
  output logic              clrLatch
);

  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(1) << STAT_BIT;

  logic hitRaw, hitMskd, hitMask, hitClear;
  logic wrBit;
  logic unusedWrBits;

  assign hitRaw   = (regAddr == ADDR_W'(SEL_RAW));
  assign hitMskd  = (regAddr == ADDR_W'(SEL_MSKD));
  assign hitMask  = (regAddr == ADDR_W'(SEL_MASK));
  assign hitClear = (regAddr == ADDR_W'(SEL_CLEAR));

  assign wrBit        = regWrData[STAT_BIT];
  assign unusedWrBits = ^(regWrData & ~FIELD_MASK);

  assign clrWrite = regWrEn && hitClear;

  // Latch follows every clear write; it falls back to 0 only while the flag is 0
  always_ff @(posedge clk) begin
    if (!rstN)           clrLatch <= 1'b0;
    else if (clrWrite)   clrLatch <= wrBit;
    else if (!rawStatus) clrLatch <= 1'b0;
  end

  always_comb begin
    strobe         = '0;
    strobe.maskWe  = regWrEn && hitMask;
    strobe.maskVal = wrBit;
    strobe.clrEvt  = clrWrite && wrBit && !clrLatch;
  end

  always_comb begin
    regRdData = '0;
    if (hitRaw)       regRdData[STAT_BIT] = rawStatus;
    else if (hitMskd) regRdData[STAT_BIT] = rawStatus && maskBit;
    else if (hitMask) regRdData[STAT_BIT] = maskBit;
  end

endmodule

// File: rtl/cts_edge_irq.sv
module cts_edge_irq
  import cts_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctsIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              rawStatus,
  output logic              maskedStatus,
  output logic              irqOut
);

  ctlStrobe_t strobe;
  logic       edgeSeen;
  logic       maskBit;
  logic       clrWrite;
  logic       clrLatch;
  logic       clrEvt;

  cts_irq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .rawStatus (rawStatus),
    .maskBit   (maskBit),
    .strobe    (strobe),
    .regRdData (regRdData),
    .clrWrite  (clrWrite),
    .clrLatch  (clrLatch)
  );

  cts_irq_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctsIn     (ctsIn),
    .strobe    (strobe),
    .edgeSeen  (edgeSeen),
    .rawStatus (rawStatus),
    .maskBit   (maskBit)
  );

  assign clrEvt       = strobe.clrEvt;
  assign maskedStatus = rawStatus && maskBit;
  assign irqOut       = maskedStatus;

endmodule

// File: rtl/cts_edge_irq_chk.sv
module cts_edge_irq_chk (
  input logic clk,
  input logic rstN,
  input logic edgeSeen,
  input logic clrEvt,
  input logic clrWrite,
  input logic clrLatch,
  input logic rawStatus,
  input logic maskedStatus,
  input logic irqOut
);

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> rawStatus) else $error("a_r2_edge_sets");

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvt && !edgeSeen) |=> !rawStatus) else $error("a_r3_clear_takes");

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvt && edgeSeen) |=> (rawStatus && clrLatch)) else $error("a_r4_set_wins");

  a_r5_latched_blocks: assert property (@(posedge clk) disable iff (!rstN)
    clrLatch |-> !clrEvt) else $error("a_r5_latched_blocks");

  a_r6_latch_release: assert property (@(posedge clk) disable iff (!rstN)
    (!rawStatus && !clrWrite) |=> !clrLatch) else $error("a_r6_latch_release");

  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeSeen && !clrEvt) |=> $stable(rawStatus)) else $error("a_r10_flag_holds");

  always @(posedge clk) begin
    if (rstN) begin
      a_r7_irq_follows: assert (irqOut == maskedStatus) else $error("a_r7_irq_follows");
      a_r7_masked_sub: assert (!maskedStatus || rawStatus) else $error("a_r7_masked_sub");
    end
  end

endmodule

bind cts_edge_irq cts_edge_irq_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .edgeSeen     (edgeSeen),
  .clrEvt       (clrEvt),
  .clrWrite     (clrWrite),
  .clrLatch     (clrLatch),
  .rawStatus    (rawStatus),
  .maskedStatus (maskedStatus),
  .irqOut       (irqOut)
);

// File: tb/cts_edge_irq_tb_top.sv
module cts_edge_irq_tb_top;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              ctsIn;
  logic [ADDR_W-1:0] regAddr;
  logic              regWrEn;
  logic [DATA_W-1:0] regWrData;
  logic [DATA_W-1:0] regRdData;
  logic              rawStatus;
  logic              maskedStatus;
  logic              irqOut;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cts_edge_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctsIn        (ctsIn),
    .regAddr      (regAddr),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .irqOut       (irqOut)
  );

  // One clock cycle of stimulus and the raw flag expected after its edge
  typedef struct packed {
    logic       cts;
    logic       we;
    logic [1:0] addr;
    logic       dbit;
    logic       expRaw;
    logic [3:0] req;
  } stepT;

  localparam int NSTEP = 21;
  localparam stepT STEPS [0:NSTEP-1] = '{
    '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1},   // R1 idle after reset
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},   // R2 rise applied
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 4'd2},   // R2 flag after third edge
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 4'd10},  // R10 hold
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 4'd3},   // R3 clear
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},   // R2 fall applied
    '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd2},
    '{1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 4'd3},   // R3 clear after auto release
    '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd6},
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 4'd4},   // R4 clear collides with change
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 4'd5},   // R5 locked
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 4'd5},
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 4'd5},   // R5 still locked
    '{1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 4'd5},   // R5 write 0 keeps flag
    '{1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 4'd6},   // R6 recovery
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd6}
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    regWrEn   = 1'b0;
    regAddr   = '0;
    regWrData = '0;
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    regWrEn   = 1'b1;
    regAddr   = a;
    regWrData = d;
    step();
    idle();
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    regWrEn = 1'b0;
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    rstN  = 1'b0;
    ctsIn = 1'b0;
    idle();
    @(negedge clk);
    repeat (3) step();
    rstN = 1'b1;

    // R1 reset state
    check("R1 raw", {15'd0, rawStatus}, 16'd0);
    check("R1 irq", {15'd0, irqOut}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      readReg(ADDR_W'(a), rd);
      check("R1 read", rd, 16'd0);
    end
    idle();

    // Cycle table
    for (int k = 0; k < NSTEP; k++) begin
      ctsIn     = STEPS[k].cts;
      regWrEn   = STEPS[k].we;
      regAddr   = STEPS[k].addr;
      regWrData = STEPS[k].dbit ? 16'h0002 : 16'h0000;
      step();
      checks++;
      if (rawStatus !== STEPS[k].expRaw) begin
        errors++;
        $display("FAIL R%0d step %0d: actual=%b expected=%b",
                 STEPS[k].req, k, rawStatus, STEPS[k].expRaw);
      end
    end
    idle();

    // R8 clear register reads zero
    readReg(2'd3, rd);
    check("R8 clear reads 0", rd, 16'd0);

    // R7 mask write with all bits set, R8 only bit 1 returned
    writeReg(2'd2, 16'hFFFF);
    readReg(2'd2, rd);
    check("R8 mask read", rd, 16'h0002);
    check("R7 masked with raw 0", {15'd0, maskedStatus}, 16'd0);

    // Raise the flag: fall on CTS, flag after three edges
    ctsIn = 1'b0;
    repeat (3) step();
    check("R7 masked", {15'd0, maskedStatus}, 16'd1);
    check("R7 irq", {15'd0, irqOut}, 16'd1);
    readReg(2'd0, rd);
    check("R8 raw read", rd, 16'h0002);
    readReg(2'd1, rd);
    check("R8 masked read", rd, 16'h0002);

    // R9 writes to read-only words ignored
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'h0000);
    check("R9 raw kept", {15'd0, rawStatus}, 16'd1);
    readReg(2'd1, rd);
    check("R9 masked read kept", rd, 16'h0002);

    // R7 mask off
    writeReg(2'd2, 16'h0000);
    check("R7 masked off", {15'd0, maskedStatus}, 16'd0);
    check("R7 irq off", {15'd0, irqOut}, 16'd0);
    check("R7 raw unaffected", {15'd0, rawStatus}, 16'd1);

    // R1 reset mid-run
    rstN = 1'b0;
    step();
    rstN = 1'b1;
    check("R1 raw after reset", {15'd0, rawStatus}, 16'd0);
    readReg(2'd2, rd);
    check("R1 mask after reset", rd, 16'd0);
    idle();

    done = 1'b1;
    summary();
  end

endmodule